// File: doc/BRIEF.md
# Reloading Countdown Timer with Interrupt

A memory-mapped countdown timer with four word registers: a start-count register, a live count register, a control register and an interrupt-acknowledge register. Software writes a start count and then enables the timer. While it is enabled, the counter steps down by one on each qualified tick strobe. A control bit picks which of two one-cycle tick inputs qualifies.

When the counter is at zero and receives a step, it underflows and raises a level interrupt. In periodic mode the counter then reloads the start count. In free-run mode it wraps to the all-ones value of its width. The counter width is a parameter, typically 16 or 32 bits.

Software reprograms the timer in three writes: control with enable clear, then the start count, then control with enable set. Register access is a single-cycle port. Writes take effect at the clock edge. Reads are combinational on the word address.

Top module: `cdtimer`

## Requirements
- R1: After reset the start-count register (word offset 0x00), count register (0x04) and control register (0x08) read zero, and `irq` is low.
- R2: The counter steps down by one only on a qualified tick while the enable bit (control bit 7) is set. With enable clear, ticks leave the count unchanged.
- R3: Control bit 3 selects the tick source. When it is 1, only `tick_fast` qualifies. When it is 0, only `tick_slow` qualifies.
- R4: Writing the start-count register stores the value and also loads the counter on the same edge.
- R5: Control reads back bits 7, 6 and 3 as written. All other control bits read zero.
- R6: A step taken while the count is zero sets `irq`.
- R7: `irq` is level-high and stays set across further ticks and underflows until it is acknowledged.
- R8: Any write to the acknowledge register (0x0C) clears `irq`, whatever data is written.
- R9: With control bit 6 (mode) set, an underflow reloads the start count. With bit 6 clear, the counter wraps to all ones.
- R10: If an underflow and an acknowledge write fall on the same edge, `irq` ends set.
- R11: The count register is read-only. Writes to offset 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Fast tick strobe |
| tick_slow | input | 1 | Slow tick strobe |
| irq | output | 1 | Underflow interrupt, level-high |

## Verification
A corrupted count shows on the count register at the next read. It also shows as an interrupt that arrives one or more ticks early or late, so a wrong decrement is visible within a single tick. A lost mode or source-select bit shows at the next control read. It then shows again at the next underflow, either as the wrong post-underflow value or as counting on the wrong strobe. A wrong interrupt flag shows directly on `irq` one edge after the underflow or acknowledge that should have changed it.

// File: rtl/cdtimer.sv
module cdtimer #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  localparam logic [1:0] W_START = 2'd0;
  localparam logic [1:0] W_COUNT = 2'd1;
  localparam logic [1:0] W_CTRL  = 2'd2;
  localparam logic [1:0] W_ACK   = 2'd3;
  localparam int B_EN   = 7;
  localparam int B_PER  = 6;
  localparam int B_FAST = 3;

  logic [CNT_W-1:0] start_q, count_q;
  logic             en_q, per_q, fast_q;

  wire [1:0] word     = bus_addr[3:2];
  wire       wr_start = bus_wr && word == W_START;
  wire       wr_ctrl  = bus_wr && word == W_CTRL;
  wire       wr_ack   = bus_wr && word == W_ACK;
  wire       step     = en_q && (fast_q ? tick_fast : tick_slow);
  wire       under    = step && count_q == '0;

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, bus_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
      en_q    <= 1'b0;
      per_q   <= 1'b0;
      fast_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[B_EN];
        per_q  <= bus_wdata[B_PER];
        fast_q <= bus_wdata[B_FAST];
      end
      if (wr_start) begin
        start_q <= bus_wdata[CNT_W-1:0];
        count_q <= bus_wdata[CNT_W-1:0];
      end else if (under)
        count_q <= per_q ? start_q : '1;
      else if (step)
        count_q <= count_q - 1'b1;
      if (under)
        irq <= 1'b1;
      else if (wr_ack)
        irq <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (word)
      W_START: bus_rdata = DATA_W'(start_q);
      W_COUNT: bus_rdata = DATA_W'(count_q);
      W_CTRL: begin
        bus_rdata[B_EN]   = en_q;
        bus_rdata[B_PER]  = per_q;
        bus_rdata[B_FAST] = fast_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_start) |=> $stable(count_q));
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q != '0 && !wr_start) |=> count_q == $past(count_q) - 1'b1);
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> count_q == $past(bus_wdata[CNT_W-1:0]));
  p_underflow_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    under |=> irq);
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ack) |=> irq);
  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && !under) |=> !irq);
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (under && per_q && !wr_start) |=> count_q == $past(start_q));
  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !per_q && !wr_start) |=> count_q == '1);
endmodule

// File: tb/cdtimer_test.sv
module cdtimer_test;
  localparam int CW = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic        irq;

  cdtimer #(.CNT_W(CW), .DATA_W(32), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_fast(tick_fast), .tick_slow(tick_slow), .irq(irq));

  always #10 clk = ~clk;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tk(input bit fast);
    tick_fast = fast; tick_slow = !fast;
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_reg(4'h0, 32'h0, "R1 start");
    exp_reg(4'h4, 32'h0, "R1 count");
    exp_reg(4'h8, 32'h0, "R1 ctrl");
    exp_irq(1'b0, "R1 irq");

    wr(4'h0, 32'h0000_0003);
    exp_reg(4'h4, 32'd3, "R4 count loaded");
    exp_reg(4'h0, 32'd3, "R4 start stored");

    wr(4'h8, 32'hFF);
    exp_reg(4'h8, 32'hC8, "R5 unused bits zero");
    wr(4'h8, 32'hC8);
    exp_reg(4'h8, 32'hC8, "R5 readback");

    tk(0);
    exp_reg(4'h4, 32'd3, "R3 slow ignored when fast chosen");
    tk(1); exp_reg(4'h4, 32'd2, "R2 step");
    tk(1); tk(1);
    exp_reg(4'h4, 32'd0, "R2 reached zero");
    exp_irq(1'b0, "R6 no irq before underflow");
    tk(1);
    exp_irq(1'b1, "R6 underflow irq");
    exp_reg(4'h4, 32'd3, "R9 periodic reload");
    tk(1);
    exp_irq(1'b1, "R7 irq sticky");
    wr(4'hC, 32'h0);
    exp_irq(1'b0, "R8 ack clears");

    wr(4'h8, 32'h48);
    tk(1);
    exp_reg(4'h4, 32'd2, "R2 disabled holds");

    wr(4'h8, 32'h80);
    tk(1);
    exp_reg(4'h4, 32'd2, "R3 fast ignored when slow chosen");
    tk(0); tk(0);
    exp_reg(4'h4, 32'd0, "R3 slow counts");
    tk(0);
    exp_reg(4'h4, 32'h0000FFFF, "R9 free-run wrap");
    exp_irq(1'b1, "R6 irq after wrap");
    wr(4'hC, 32'hDEAD_BEEF);
    exp_irq(1'b0, "R8 ack any data");

    wr(4'h8, 32'h0);
    wr(4'h0, 32'd5);
    wr(4'h8, 32'h88);
    exp_reg(4'h4, 32'd5, "R4 reprogram");
    tk(1);
    exp_reg(4'h4, 32'd4, "R2 after reprogram");

    wr(4'h4, 32'h1234);
    exp_reg(4'h4, 32'd4, "R11 count read-only");
    exp_reg(4'h0, 32'd5, "R11 start untouched");

    wr(4'h0, 32'd0);
    bus_addr = 4'hC; bus_wdata = 32'h1; bus_wr = 1'b1; tick_fast = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0;
    exp_irq(1'b1, "R10 underflow beats ack");

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule